// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

A register-mapped timer bank with `NCH` independent 32-bit down counters (two by default). Each channel picks one of four shared source-tick inputs, divides it by a power of two and, while running, decrements its counter once per divided tick. When a running counter is at zero and another divided tick arrives, the channel expires. It raises its status bit and then either reloads from its interval register (periodic) or stops (one-shot). With an interval of all ones in periodic mode, a channel is a wrapping 32-bit free-running counter.

Software reaches the block over a simple synchronous bus with separate write and read strobes. Read data appears one clock after the read strobe. A single interrupt line combines every channel's status bit with its own enable bit. Turning a channel on or off takes effect only after a fixed number of ticks of its selected source. This latency stands in for crossing into a separate timer clock.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads 0, and `irq` is 0. Reads of unmapped or misaligned offsets return 0. Read data is valid one clock after `bus_rd`.
- R2: Address map: 0x00 is the interrupt enable register (bit n for channel n). 0x04 is the interrupt status register. Channel n uses 0x10*(n+1) for control, +0x04 for interval and +0x08 for the read-only count. Control fields are: bit 0 enable, bit 1 load, bits [3:2] source, bits [6:4] divider exponent, and bit 7 one-shot. A control write with bit 1 set copies the interval into the counter at that clock edge. Bit 1 always reads back as 0.
- R3: A channel responds only to the `src_tick` bit named by its source field. Ticks on other sources leave its count and status unchanged.
- R4: After the enable bit goes from 0 to 1, the first two selected source ticks do not decrement the counter. The third tick is the first that can.
- R5: With divider exponent N, the counter decrements once per 2^N selected source ticks. A control write restarts the divider, so the 2^N-th tick after the write is the first to decrement.
- R6: After the enable bit is cleared, the channel keeps decrementing on the next two selected source ticks and then halts.
- R7: In periodic mode, a divided tick that arrives while the count is 0 sets the channel's status bit and reloads the interval.
- R8: `irq` is the OR over channels of (status bit AND enable bit). Status bits are set even when masked. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: In one-shot mode, an expiry sets the status bit, holds the count at 0 and clears the control enable bit. Later ticks change nothing.
- R10: If an expiry and a write-1-to-clear of the same status bit fall in one cycle, the bit ends up set.
- R11: If a load request and a decrement or expiry fall in one cycle, the counter takes the interval value.
- R12: In periodic mode with interval 0xFFFFFFFF, an expiry at 0 reloads 0xFFFFFFFF, and the next tick gives 0xFFFFFFFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| src_tick | input | 4 | Source tick pulses; bit k is source k |
| irq | output | 1 | Combined masked interrupt |

## Verification
Two pairs of events can land in the same clock. The first pair is a channel expiring while software writes 1 to clear that channel's status bit. The second pair is a divided tick arriving while software writes a control word with the load bit set. The bench raises the source tick and the bus write on the same clock edge to provoke each pair. It then reads back the status register and the count register. It expects the status bit to stay set and the counter to hold the interval, not the decremented or reloaded value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SRC_W  = 2;
  localparam int NSRC   = 1 << SRC_W;
  localparam int PRE_W  = 3;
  localparam int DIV_W  = (1 << PRE_W) - 1;
  localparam int BIT_EN = 0;
  localparam int BIT_LD = 1;

  typedef struct packed {
    logic              one_shot;
    logic [PRE_W-1:0]  pre;
    logic [SRC_W-1:0]  src;
    logic              en;
  } chan_cfg_t;

  // mask of low divider bits that must all be 1 for a divided tick
  function automatic logic [DIV_W-1:0] div_mask(input logic [PRE_W-1:0] n);
    logic [DIV_W:0] one;
    one = (DIV_W+1)'(1) << n;
    return DIV_W'(one - 1'b1);
  endfunction

  function automatic chan_cfg_t word_to_cfg(input logic [31:0] w);
    chan_cfg_t c;
    c.en       = w[0];
    c.src      = w[3:2];
    c.pre      = w[6:4];
    c.one_shot = w[7];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input chan_cfg_t c);
    return {24'd0, c.one_shot, c.pre, c.src, 1'b0, c.en};
  endfunction
endpackage

// File: rtl/tmr_gate.sv
module tmr_gate
  import tmr_pkg::*;
#(
  parameter int SYNC_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SRC_W-1:0] src_sel,
  input  logic [PRE_W-1:0] pre,
  input  logic             en_req,
  input  logic             clr_div,
  input  logic             kill,
  output logic             run,
  output logic             step
);
  localparam int SW = $clog2(SYNC_LAT + 1);

  logic [SW-1:0]    sync_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             sel_tick;
  logic [DIV_W-1:0] mask;

  assign sel_tick = src_tick[src_sel];
  assign mask     = div_mask(pre);
  assign step     = run && sel_tick && ((div_cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      sync_cnt <= '0;
      div_cnt  <= '0;
    end else begin
      if (kill) begin
        run      <= 1'b0;
        sync_cnt <= '0;
      end else if (en_req == run) begin
        sync_cnt <= '0;
      end else if (sel_tick) begin
        if (sync_cnt == SW'(SYNC_LAT - 1)) begin
          run      <= en_req;
          sync_cnt <= '0;
        end else begin
          sync_cnt <= sync_cnt + 1'b1;
        end
      end
      if (clr_div || !run) div_cnt <= '0;
      else if (sel_tick)   div_cnt <= div_cnt + 1'b1;
    end
  end

  // R4
  run_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(run) |-> ($past(sel_tick) || $past(kill)));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic         one_shot,
  input  logic [W-1:0] ivl,
  output logic [W-1:0] count,
  output logic         expire
);
  assign expire = step && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (load)   count <= ivl;
    else if (expire) count <= one_shot ? '0 : ivl;
    else if (step)   count <= count - 1'b1;
  end

  // R5
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && count != '0) |=> count == $past(count) - 1'b1);
  // R7
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !one_shot && !load) |=> count == $past(ivl));
  // R9
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && one_shot && !load) |=> count == '0);
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(count));
  // R11
  load_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(ivl));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int AW       = 8,
  parameter int SYNC_LAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] src_tick,
  output logic            irq
);
  localparam int BLKW = AW - 4;

  logic [BLKW-1:0] blk;
  logic [1:0]      sub;
  logic            aligned;
  logic            ien_wr, ist_wr;
  logic [NCH-1:0]  irq_en, irq_st;
  logic [NCH-1:0]  ctl_wr, ivl_wr, expire_v, kill_v;
  chan_cfg_t       cfg_q [NCH];
  logic [31:0]     ivl_q [NCH];
  logic [31:0]     cnt_v [NCH];
  logic [31:0]     rd_word;

  assign blk     = bus_addr[AW-1:4];
  assign sub     = bus_addr[3:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign ien_wr  = bus_wr && aligned && blk == '0 && sub == 2'd0;
  assign ist_wr  = bus_wr && aligned && blk == '0 && sub == 2'd1;

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      logic run, step;

      assign ctl_wr[i] = bus_wr && aligned && blk == BLKW'(i + 1) && sub == 2'd0;
      assign ivl_wr[i] = bus_wr && aligned && blk == BLKW'(i + 1) && sub == 2'd1;
      assign kill_v[i] = expire_v[i] && cfg_q[i].one_shot;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg_q[i] <= '0;
          ivl_q[i] <= '0;
        end else begin
          if (ctl_wr[i])      cfg_q[i]    <= word_to_cfg(bus_wdata);
          else if (kill_v[i]) cfg_q[i].en <= 1'b0;
          if (ivl_wr[i])      ivl_q[i]    <= bus_wdata;
        end
      end

      tmr_gate #(.SYNC_LAT(SYNC_LAT)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_tick(src_tick),
        .src_sel (cfg_q[i].src),
        .pre     (cfg_q[i].pre),
        .en_req  (cfg_q[i].en),
        .clr_div (ctl_wr[i]),
        .kill    (kill_v[i]),
        .run     (run),
        .step    (step)
      );

      tmr_count #(.W(32)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .load    (ctl_wr[i] && bus_wdata[BIT_LD]),
        .one_shot(cfg_q[i].one_shot),
        .ivl     (ivl_q[i]),
        .count   (cnt_v[i]),
        .expire  (expire_v[i])
      );

      // R10
      st_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_v[i] |=> irq_st[i]);
      // R9
      oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_v[i] && !ctl_wr[i]) |=> !cfg_q[i].en);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= '0;
      irq_st <= '0;
    end else begin
      if (ien_wr) irq_en <= bus_wdata[NCH-1:0];
      irq_st <= (irq_st & ~(ist_wr ? bus_wdata[NCH-1:0] : '0)) | expire_v;
    end
  end

  assign irq = |(irq_st & irq_en);

  always_comb begin
    rd_word = '0;
    if (aligned && blk == '0) begin
      case (sub)
        2'd0:    rd_word[NCH-1:0] = irq_en;
        2'd1:    rd_word[NCH-1:0] = irq_st;
        default: rd_word = '0;
      endcase
    end
    for (int k = 0; k < NCH; k++) begin
      if (aligned && blk == BLKW'(k + 1)) begin
        case (sub)
          2'd0:    rd_word = cfg_to_word(cfg_q[k]);
          2'd1:    rd_word = ivl_q[k];
          2'd2:    rd_word = cnt_v[k];
          default: rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
    else             bus_rdata <= '0;
  end

  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wr));
  // R2
  ld_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sub == 2'd0 && blk != '0) |=> !bus_rdata[BIT_LD]);
endmodule

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick = '0;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;

  always #2 clk = ~clk;

  tmr_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_tick(src_tick), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic tick(input logic [3:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); src_tick = m;
      @(negedge clk); src_tick = '0;
    end
  endtask

  // tick and bus write on the same clock edge
  task automatic tick_wr(input logic [3:0] m, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); src_tick = m; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); src_tick = '0; bus_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({31'd0, irq}, 32'd0, "R1 irq after reset");
    rst_n = 1'b1;
    rd_exp(8'h00, 0, "R1 ien reset");
    rd_exp(8'h04, 0, "R1 ist reset");
    rd_exp(8'h10, 0, "R1 ctl0 reset");
    rd_exp(8'h24, 0, "R1 ivl1 reset");
    rd_exp(8'h18, 0, "R1 cnt0 reset");
    wr(8'h14, 32'd5);
    rd_exp(8'h0C, 0, "R1 unmapped");
    rd_exp(8'h15, 0, "R1 misaligned");
    // R2 load on control write
    wr(8'h10, 32'h03);
    rd_exp(8'h18, 32'd5, "R2 loaded count");
    rd_exp(8'h10, 32'h01, "R2 load bit reads 0");
    // R4 enable latency
    tick(4'b0001, 2);
    rd_exp(8'h18, 32'd5, "R4 no decrement during sync");
    tick(4'b0001, 1);
    rd_exp(8'h18, 32'd4, "R4 third tick decrements");
    // R5 divide by 4
    wr(8'h10, 32'h21);
    tick(4'b0001, 3);
    rd_exp(8'h18, 32'd4, "R5 three ticks no step");
    tick(4'b0001, 1);
    rd_exp(8'h18, 32'd3, "R5 fourth tick steps");
    // R7 periodic expiry
    wr(8'h10, 32'h01);
    tick(4'b0001, 3);
    rd_exp(8'h18, 32'd0, "R7 reached zero");
    rd_exp(8'h04, 32'd0, "R7 no status before expiry");
    tick(4'b0001, 1);
    rd_exp(8'h18, 32'd5, "R7 reloaded");
    rd_exp(8'h04, 32'd1, "R7 status set");
    check({31'd0, irq}, 32'd0, "R8 masked irq");
    wr(8'h00, 32'd1);
    check({31'd0, irq}, 32'd1, "R8 irq on enable");
    wr(8'h04, 32'd0);
    rd_exp(8'h04, 32'd1, "R8 write 0 keeps status");
    wr(8'h04, 32'd1);
    check({31'd0, irq}, 32'd0, "R8 irq after clear");
    rd_exp(8'h04, 32'd0, "R8 status cleared");
    // R6 disable latency
    wr(8'h10, 32'h00);
    tick(4'b0001, 2);
    rd_exp(8'h18, 32'd3, "R6 two ticks after disable");
    tick(4'b0001, 2);
    rd_exp(8'h18, 32'd3, "R6 halted");
    // R9 one-shot
    wr(8'h14, 32'd2);
    wr(8'h10, 32'h83);
    tick(4'b0001, 4);
    rd_exp(8'h18, 32'd0, "R9 count at zero");
    tick(4'b0001, 1);
    rd_exp(8'h04, 32'd1, "R9 status on expiry");
    rd_exp(8'h10, 32'h80, "R9 enable cleared");
    check({31'd0, irq}, 32'd1, "R9 irq raised");
    tick(4'b0001, 3);
    rd_exp(8'h18, 32'd0, "R9 held at zero");
    wr(8'h04, 32'd1);
    // R3 source select on channel 1
    wr(8'h20, 32'h07);
    tick(4'b0010, 2);
    tick(4'b0001, 2);
    rd_exp(8'h04, 32'd0, "R3 other source ignored");
    rd_exp(8'h28, 32'd0, "R3 count unchanged");
    // R10 expiry and clear together
    tick_wr(4'b0010, 8'h04, 32'd2);
    rd_exp(8'h04, 32'd2, "R10 set wins over clear");
    check({31'd0, irq}, 32'd0, "R8 channel 1 masked");
    wr(8'h04, 32'd2);
    rd_exp(8'h04, 32'd0, "R10 cleared afterwards");
    // R11 load and expiry together
    wr(8'h24, 32'd7);
    tick_wr(4'b0010, 8'h20, 32'h07);
    rd_exp(8'h28, 32'd7, "R11 load wins");
    tick(4'b0010, 1);
    rd_exp(8'h28, 32'd6, "R11 decrement after load");
    // R12 free-running wrap on channel 0
    wr(8'h14, 32'd0);
    wr(8'h10, 32'h03);
    wr(8'h14, 32'hFFFF_FFFF);
    tick(4'b0001, 2);
    rd_exp(8'h18, 32'd0, "R12 zero before wrap");
    tick(4'b0001, 1);
    rd_exp(8'h18, 32'hFFFF_FFFF, "R12 wrapped");
    tick(4'b0001, 1);
    rd_exp(8'h18, 32'hFFFF_FFFE, "R12 continues down");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule